// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block runs on the host side of a flash device. It decides whether an embedded program or erase operation has finished. It does this by reading the device status byte and watching one bit that alternates on every read while the operation runs. After a start pulse it reads the status byte in pairs at a latched address, using a request/acknowledge read port, and compares the alternating bit between the two reads of each pair. When the bit holds still, the operation is finished. When the bit still alternates and the timeout flag of the device is set, one more pair is read to confirm. This covers the case where the alternation stops at the same moment the flag rises. A confirmed failure, or too many busy pairs, makes the controller send a single reset command write, which returns the device to array reads.

The result is given as a 2-bit code with a one-cycle `done` strobe. The code stays stable until the next start. An `abort` input lets the host give up on the poll and do other work. A later start always begins again with a fresh first read.

States:
- `ST_IDLE`: waiting for a start pulse.
- `ST_READ_A`: first read of a pair.
- `ST_READ_B`: second read of a pair, followed by the decision.
- `ST_CONF_A`: first read of the confirming pair.
- `ST_CONF_B`: second read of the confirming pair.
- `ST_RESET_WR`: reset command write.
- `ST_REPORT`: done strobe.

Transitions:
- start: `ST_IDLE` → `ST_READ_A`.
- first ack: `ST_READ_A` → `ST_READ_B`.
- steady: `ST_READ_B` → `ST_REPORT`.
- busy: `ST_READ_B` → `ST_READ_A`.
- flagged: `ST_READ_B` → `ST_CONF_A`.
- over limit: `ST_READ_B` → `ST_RESET_WR`.
- confirm ack: `ST_CONF_A` → `ST_CONF_B`.
- confirm steady: `ST_CONF_B` → `ST_REPORT`.
- confirm toggling: `ST_CONF_B` → `ST_RESET_WR`.
- write ack: `ST_RESET_WR` → `ST_REPORT`.
- abort, from any read state: → `ST_REPORT`.
- `ST_REPORT` → `ST_IDLE`.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, the block is idle: `busy`, `done`, `rd_req` and `wr_req` are low, and `result` is 0 (no result).
- R2: A `start` pulse while idle latches `poll_addr`. In the next cycle `rd_req` and `busy` go high, with `rd_addr` equal to the latched address. A `start` while busy is ignored.
- R3: Each check reads the status byte twice. Bit 6 of the two reads is compared. If bit 6 is equal, the result is 1 (success) after exactly two reads, with no write.
- R4: If bit 6 differs and bit 5 of the second read is 0, a new pair of reads begins, starting with a fresh first read.
- R5: If bit 6 differs and bit 5 of the second read is 1, a confirming pair is read. If bit 6 is equal across that pair, the result is 1 (success) with no write.
- R6: If bit 6 still differs across the confirming pair, the result is 2 (failure) and a reset command write follows.
- R7: The reset write holds `wr_req` until `wr_ack`, with `wr_addr` equal to the polled address and `wr_data` equal to 0xF0. `done` comes only after the acknowledge.
- R8: When `MAX_PAIRS` consecutive pairs differ in bit 6 with bit 5 low, the result is 2 (failure) and a reset write follows. If `MAX_PAIRS-1` such pairs are followed by a steady pair, the result is 1.
- R9: `abort` in any read state ends the poll with result 3 (abandoned) and no write. `abort` wins over a same-cycle `rd_ack`. `abort` while idle has no effect.
- R10: A start after an abandoned poll bases its first comparison only on reads made after that start.
- R11: `done` is high for exactly one cycle. `result` holds its value from that cycle until the next start.
- R12: Status bits other than 6 and 5 never affect the outcome. Bit 5 is ignored when bit 6 did not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, honoured only when idle |
| abort | input | 1 | Abandon the current poll |
| poll_addr | input | AW | Address to poll, latched at start |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid with it |
| rd_data | input | 8 | Status byte |
| wr_req | output | 1 | Reset command write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data (0xF0) |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 0 none, 1 success, 2 failure, 3 abandoned |

## Verification
`rd_req` is due one cycle after the start edge. Each acknowledged read advances the state at that same edge. `done` rises one cycle after the deciding acknowledge: either the second read of a pair, the second confirming read, or the write acknowledge. The bench drives inputs on falling edges and samples on falling edges. A scoreboard compares the code, the number of acknowledged reads and the number of reset writes on the falling edge that shows `done`. Stability of `result` and the single-cycle strobe are then checked over the next few falling edges.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_A,
        ST_READ_B,
        ST_CONF_A,
        ST_CONF_B,
        ST_RESET_WR,
        ST_REPORT
    } poll_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_OK      = 2'd1,
        RES_FAIL    = 2'd2,
        RES_ABANDON = 2'd3
    } poll_res_e;

    localparam logic [7:0] RESET_CMD = 8'hF0;
endpackage

// File: rtl/toggle_pair_eval.sv
module toggle_pair_eval #(
    parameter int TOGGLE_BIT = 6,
    parameter int FLAG_BIT   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [7:0] status,
    output logic       toggled,
    output logic       flag
);
    logic first_q;
    logic unused_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       first_q <= 1'b0;
        else if (capture) first_q <= status[TOGGLE_BIT];
    end

    assign toggled     = first_q ^ status[TOGGLE_BIT];
    assign flag        = status[FLAG_BIT];
    assign unused_bits = ^status;
endmodule

// File: rtl/poll_pair_counter.sv
module poll_pair_counter #(
    parameter int MAX_PAIRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PAIRS + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CW'(MAX_PAIRS - 1));
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
    import tpc_pkg::*;
#(
    parameter int AW         = 24,
    parameter int MAX_PAIRS  = 8,
    parameter int TOGGLE_BIT = 6,
    parameter int FLAG_BIT   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] poll_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result
);
    poll_state_e   state_q, state_d;
    poll_res_e     result_q, result_d;
    logic [AW-1:0] addr_q;
    logic          cap_first, pair_inc, cnt_clr;
    logic          toggled, flag, at_limit;

    toggle_pair_eval #(.TOGGLE_BIT(TOGGLE_BIT), .FLAG_BIT(FLAG_BIT)) u_eval (
        .clk(clk), .rst_n(rst_n), .capture(cap_first),
        .status(rd_data), .toggled(toggled), .flag(flag)
    );

    poll_pair_counter #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(pair_inc),
        .at_limit(at_limit)
    );

    // State register and held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= RES_NONE;
            addr_q   <= '0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (state_q == ST_IDLE && start) addr_q <= poll_addr;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        result_d  = result_q;
        cap_first = 1'b0;
        pair_inc  = 1'b0;
        cnt_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_READ_A;
                    result_d = RES_NONE;
                    cnt_clr  = 1'b1;
                end
            end
            ST_READ_A, ST_CONF_A: begin
                if (abort) begin
                    state_d  = ST_REPORT;
                    result_d = RES_ABANDON;
                end else if (rd_ack) begin
                    cap_first = 1'b1;
                    state_d   = (state_q == ST_READ_A) ? ST_READ_B : ST_CONF_B;
                end
            end
            ST_READ_B: begin
                if (abort) begin
                    state_d  = ST_REPORT;
                    result_d = RES_ABANDON;
                end else if (rd_ack) begin
                    if (!toggled) begin
                        state_d  = ST_REPORT;
                        result_d = RES_OK;
                    end else if (flag) begin
                        state_d = ST_CONF_A;
                    end else begin
                        pair_inc = 1'b1;
                        if (at_limit) begin
                            state_d  = ST_RESET_WR;
                            result_d = RES_FAIL;
                        end else begin
                            state_d = ST_READ_A;
                        end
                    end
                end
            end
            ST_CONF_B: begin
                if (abort) begin
                    state_d  = ST_REPORT;
                    result_d = RES_ABANDON;
                end else if (rd_ack) begin
                    if (toggled) begin
                        state_d  = ST_RESET_WR;
                        result_d = RES_FAIL;
                    end else begin
                        state_d  = ST_REPORT;
                        result_d = RES_OK;
                    end
                end
            end
            ST_RESET_WR: begin
                if (wr_ack) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req  = (state_q == ST_READ_A) || (state_q == ST_READ_B) ||
                  (state_q == ST_CONF_A) || (state_q == ST_CONF_B);
        wr_req  = (state_q == ST_RESET_WR);
        done    = (state_q == ST_REPORT);
        busy    = (state_q != ST_IDLE);
        rd_addr = addr_q;
        wr_addr = addr_q;
        wr_data = RESET_CMD;
        result  = result_q;
    end
endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
module toggle_poll_ctrl_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          abort,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [7:0]    wr_data,
    input logic          busy,
    input logic          done,
    input logic [1:0]    result
);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
    // R11
    done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd0));
    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);
    // R7
    wr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_data == 8'hF0));
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !abort) |=> rd_req);
    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));
    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
    .busy(busy), .done(done), .result(result)
);

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;
    localparam int AW = 24;
    localparam int MP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, abort = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req, wr_req, busy, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          rd_ack = 1'b0, wr_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00, wr_data;
    logic [1:0]    result;

    always #2.5 clk = ~clk;

    toggle_poll_ctrl #(.AW(AW), .MAX_PAIRS(MP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .poll_addr(poll_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .done(done), .result(result)
    );

    typedef struct {
        logic [1:0] res;
        int         reads;
        int         writes;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] script[$];
    int         reads_seen = 0, writes_seen = 0;
    int         n_checks = 0, n_fail = 0;
    bit         finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Device model: registered acknowledges, scripted status bytes
    always @(posedge clk) begin
        if (rd_req && !rd_ack) begin
            rd_ack  <= 1'b1;
            rd_data <= (script.size() > 0) ? script.pop_front() : 8'h00;
            reads_seen++;
        end else begin
            rd_ack <= 1'b0;
        end
        if (wr_req && !wr_ack) begin
            wr_ack <= 1'b1;
            writes_seen++;
            chk(wr_data == 8'hF0, "R7 write data", int'(wr_data), 8'hF0);
            chk(wr_addr == poll_addr, "R7 write addr", int'(wr_addr), int'(poll_addr));
        end else begin
            wr_ack <= 1'b0;
        end
    end

    // Monitor: pop and compare at each done strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(result == e.res, {e.tag, " result"}, int'(result), int'(e.res));
                if (e.reads >= 0)
                    chk(reads_seen == e.reads, {e.tag, " reads"}, reads_seen, e.reads);
                chk(writes_seen == e.writes, {e.tag, " writes"}, writes_seen, e.writes);
            end
        end
    end

    // Driver: push expectation, start, optional extra start or abort, wait for done
    task automatic run_case(input logic [AW-1:0] a, input logic [1:0] res,
                            input int reads, input int writes, input string tag,
                            input int mid_start, input int abort_after_first);
        exp_t e;
        e.res = res; e.reads = reads; e.writes = writes; e.tag = tag;
        exp_q.push_back(e);
        reads_seen  = 0;
        writes_seen = 0;
        @(negedge clk);
        poll_addr = a;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_req && busy, "R2 request after start", int'({rd_req, busy}), 3);
        chk(rd_addr == a, "R2 read address", int'(rd_addr), int'(a));
        if (mid_start != 0) begin
            repeat (3) @(negedge clk);
            poll_addr = a + 24'h100;
            start     = 1'b1;
            @(negedge clk);
            start     = 1'b0;
            poll_addr = a;
        end
        if (abort_after_first != 0) begin
            while (!rd_ack) @(negedge clk);
            @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done, "R11 done one cycle", int'(done), 0);
        chk(!busy, "R11 idle after done", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(result == res, "R11 result held", int'(result), int'(res));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_req && !wr_req, "R1 idle outputs",
            int'({busy, done, rd_req, wr_req}), 0);
        chk(result == 2'd0, "R1 result none", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 steady on first pair
        script = '{8'h40, 8'h40};
        run_case(24'h001000, 2'd1, 2, 0, "R3 steady", 0, 0);

        // R12 other bits and flag without toggle ignored
        script = '{8'hC1, 8'h4E};
        run_case(24'h001004, 2'd1, 2, 0, "R12 other bits", 0, 0);
        script = '{8'h40, 8'h60};
        run_case(24'h001008, 2'd1, 2, 0, "R12 flag no toggle", 0, 0);

        // R4 one busy pair then steady
        script = '{8'h40, 8'h00, 8'h00, 8'h00};
        run_case(24'h002000, 2'd1, 4, 0, "R4 repoll", 0, 0);

        // R5 flagged, confirm steady
        script = '{8'h40, 8'h20, 8'h20, 8'h20};
        run_case(24'h003000, 2'd1, 4, 0, "R5 confirm ok", 0, 0);

        // R6 flagged, confirm still toggling
        script = '{8'h40, 8'h20, 8'h60, 8'h20};
        run_case(24'h004000, 2'd2, 4, 1, "R6 confirm fail", 0, 0);

        // R8 limit reached
        script = {};
        for (int i = 0; i < MP; i++) begin
            script.push_back(8'h40);
            script.push_back(8'h00);
        end
        run_case(24'h005000, 2'd2, 2 * MP, 1, "R8 limit fail", 0, 0);

        // R8 one short of limit, then steady
        script = {};
        for (int i = 0; i < MP - 1; i++) begin
            script.push_back(8'h40);
            script.push_back(8'h00);
        end
        script.push_back(8'h00);
        script.push_back(8'h00);
        run_case(24'h006000, 2'd1, 2 * MP, 0, "R8 under limit", 0, 0);

        // R2 start while busy ignored
        script = '{8'h40, 8'h00, 8'h00, 8'h00};
        run_case(24'h007000, 2'd1, 4, 0, "R2 start while busy", 1, 0);

        // R9 abort after first read
        script = {};
        for (int i = 0; i < 20; i++) script.push_back(8'h40);
        run_case(24'h008000, 2'd3, -1, 0, "R9 abort", 0, 1);

        // R9 abort while idle has no effect
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        @(negedge clk);
        chk(result == 2'd3 && !busy && !rd_req, "R9 idle abort ignored",
            int'({busy, rd_req, result}), 3);

        // R10 restart uses fresh reads (a stale first sample would show a toggle)
        script = '{8'h00, 8'h00};
        run_case(24'h009000, 2'd1, 2, 0, "R10 fresh restart", 0, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule